// File: doc/BRIEF.md
# Luminance DC-Size Codeword Decoder

This block turns a serial bitstream into the sequence of luminance DC-size symbols it carries. The stream arrives as 32-bit words, and the first bit of the stream is bit 31 of the first word. An internal bit buffer holds the words. Each cycle, the decoder looks at a left-aligned window of 11 bits, which is the length of the longest codeword. From that single window it resolves both the symbol and the number of bits it occupies. No lookup memory indexed by the window value is used.

The codeword set has two groups:
- Short codes of up to five bits carry sizes 0 to 6.
- Long codes of six to eleven bits, which start with five zeros, carry sizes 7 to 12.

Both groups are examined at the same time. The short group has priority when it matches, and the long group's result is used otherwise. The buffer drops the bits of each decoded codeword on the same clock edge that registers the result. It asks for a new word whenever fewer than 11 bits are left. A host uses the block by answering `word_req` with words and collecting one registered symbol per valid output cycle.

Top module: `dcsz_vld_top`

## Requirements
- R1: The short codes decode as follows, with `sym_len` equal to the code's bit count: `11`→1, `10`→2, `011`→0, `010`→3, `001`→4, `0001`→5 and `00001`→6.
- R2: A window whose first one follows k leading zeros, with 3 ≤ k ≤ 10, decodes to size k+2 with length k+1. The cases k ≥ 5 form the long group, sizes 7 to 12.
- R3: A window of eleven zeros sets `sym_err`, with `sym_size` = 0 and `sym_len` = 0. Because no bits are consumed, the error repeats on every following cycle.
- R4: Symbols of a stream written back to back come out in stream order. After each symbol the window moves forward by exactly that symbol's length.
- R5: Stream bits are taken from each word starting at bit 31 and going down to bit 0, and words are taken in the order they are accepted.
- R6: `word_req` is high exactly when fewer than 11 bits are buffered. A word is accepted on a clock edge where `word_req` and `word_valid` are both high. The cycle after `word_req` is high, `sym_valid` is low.
- R7: The latency per symbol is constant. Whenever `word_req` is low, `sym_valid` is high on the next cycle, whatever the codeword length.
- R8: After reset, `sym_valid` and `sym_err` are low and `word_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_data | input | 32 | Refill word, first stream bit in bit 31 |
| word_valid | input | 1 | Refill word present |
| word_req | output | 1 | Buffer holds fewer than 11 bits |
| sym_valid | output | 1 | Registered symbol present |
| sym_size | output | 4 | Decoded DC size |
| sym_len | output | 4 | Bits consumed by the symbol |
| sym_err | output | 1 | Window matched no codeword |

## Verification
The first part of the stream holds all thirteen codewords in ascending size order, one after another. This tells apart every short-group branch and every long-group zero count, and shows that each advance lands on the next codeword. A seeded random run of a few hundred codewords follows. It spans word boundaries at every offset, so an advance or refill error shows up as a wrong symbol further on. The stream ends in an all-zero tail, which separates the error path from the size-12 code. That code differs from the tail only in its final one bit.

// File: rtl/dcsz_pkg.sv
package dcsz_pkg;

   localparam int unsigned SZ_W = 4;

   typedef struct packed {
      logic            hit;
      logic [SZ_W-1:0] size;
      logic [SZ_W-1:0] len;
   } dcsz_res_t;

endpackage

// File: rtl/dcsz_grp_short.sv
module dcsz_grp_short
   import dcsz_pkg::*;
#(
   parameter int unsigned WIN_W   = 11,
   parameter int unsigned SHORT_W = 5
) (
   input  logic [WIN_W-1:0] win,
   output dcsz_res_t        res
);

   localparam int unsigned TOP = WIN_W - 1;

   if (SHORT_W != 5) begin : g_bad_short
      $error("dcsz_grp_short: short group must span five bits");
   end

   always_comb begin
      res = '0;
      if (win[TOP]) begin
         res.hit  = 1'b1;
         res.len  = SZ_W'(2);
         res.size = win[TOP-1] ? SZ_W'(1) : SZ_W'(2);
      end else if (win[TOP-1]) begin
         res.hit  = 1'b1;
         res.len  = SZ_W'(3);
         res.size = win[TOP-2] ? SZ_W'(0) : SZ_W'(3);
      end else if (win[TOP-2]) begin
         res.hit  = 1'b1;
         res.len  = SZ_W'(3);
         res.size = SZ_W'(4);
      end else if (win[TOP-3]) begin
         res.hit  = 1'b1;
         res.len  = SZ_W'(4);
         res.size = SZ_W'(5);
      end else if (win[TOP-4]) begin
         res.hit  = 1'b1;
         res.len  = SZ_W'(5);
         res.size = SZ_W'(6);
      end
   end

endmodule

// File: rtl/dcsz_grp_long.sv
module dcsz_grp_long
   import dcsz_pkg::*;
#(
   parameter int unsigned WIN_W   = 11,
   parameter int unsigned SHORT_W = 5
) (
   input  logic [WIN_W-1:0] win,
   output dcsz_res_t        res
);

   localparam int unsigned LONG_W = WIN_W - SHORT_W;

   logic [LONG_W-1:0] tail;
   logic [LONG_W-1:0] first;

   assign tail = win[LONG_W-1:0];

   for (genvar g = 0; g < LONG_W; g++) begin : g_first
      if (g == 0) begin : g_lead
         assign first[g] = tail[LONG_W-1];
      end else begin : g_rest
         assign first[g] = tail[LONG_W-1-g] & ~(|tail[LONG_W-1 -: g]);
      end
   end

   always_comb begin
      res = '0;
      for (int g = 0; g < LONG_W; g++) begin
         if (first[g]) begin
            res.hit  = 1'b1;
            res.size = SZ_W'(SHORT_W + 2 + g);
            res.len  = SZ_W'(SHORT_W + 1 + g);
         end
      end
   end

endmodule

// File: rtl/dcsz_decode.sv
module dcsz_decode
   import dcsz_pkg::*;
#(
   parameter int unsigned WIN_W   = 11,
   parameter int unsigned SHORT_W = 5
) (
   input  logic [WIN_W-1:0] win,
   output logic [SZ_W-1:0]  size,
   output logic [SZ_W-1:0]  len,
   output logic             err
);

   dcsz_res_t r_short;
   dcsz_res_t r_long;

   dcsz_grp_short #(.WIN_W(WIN_W), .SHORT_W(SHORT_W)) u_short (
      .win (win),
      .res (r_short)
   );

   dcsz_grp_long #(.WIN_W(WIN_W), .SHORT_W(SHORT_W)) u_long (
      .win (win),
      .res (r_long)
   );

   always_comb begin
      size = '0;
      len  = '0;
      err  = 1'b0;
      if (r_short.hit) begin
         size = r_short.size;
         len  = r_short.len;
      end else if (r_long.hit) begin
         size = r_long.size;
         len  = r_long.len;
      end else begin
         err = 1'b1;
      end
   end

endmodule

// File: rtl/dcsz_bitbuf.sv
module dcsz_bitbuf #(
   parameter int unsigned WIN_W  = 11,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned LEN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_data,
   input  logic              word_valid,
   output logic              word_req,
   output logic [WIN_W-1:0]  win,
   output logic              win_ok,
   input  logic [LEN_W-1:0]  adv_len
);

   localparam int unsigned BUF_W = 2 * WORD_W;
   localparam int unsigned CNT_W = $clog2(BUF_W + 1);

   if (BUF_W < WIN_W - 1 + WORD_W) begin : g_bad_buf
      $error("dcsz_bitbuf: buffer too narrow for a refill below one window");
   end
   if ((1 << LEN_W) <= WIN_W) begin : g_bad_len
      $error("dcsz_bitbuf: length field cannot hold a full window");
   end

   logic [BUF_W-1:0] bits_q;
   logic [CNT_W-1:0] cnt_q;
   logic [BUF_W-1:0] fill_word;

   assign win      = bits_q[BUF_W-1 -: WIN_W];
   assign win_ok   = (cnt_q >= CNT_W'(WIN_W));
   assign word_req = ~win_ok;
   assign fill_word = {word_data, {(BUF_W-WORD_W){1'b0}}} >> cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q <= '0;
         cnt_q  <= '0;
      end else if (win_ok) begin
         bits_q <= bits_q << adv_len;
         cnt_q  <= cnt_q - CNT_W'(adv_len);
      end else if (word_valid) begin
         bits_q <= bits_q | fill_word;
         cnt_q  <= cnt_q + CNT_W'(WORD_W);
      end
   end

endmodule

// File: rtl/dcsz_vld_top.sv
module dcsz_vld_top
   import dcsz_pkg::*;
#(
   parameter int unsigned WIN_W   = 11,
   parameter int unsigned SHORT_W = 5,
   parameter int unsigned WORD_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_data,
   input  logic              word_valid,
   output logic              word_req,
   output logic              sym_valid,
   output logic [SZ_W-1:0]   sym_size,
   output logic [SZ_W-1:0]   sym_len,
   output logic              sym_err
);

   if (WIN_W != 11) begin : g_bad_win
      $error("dcsz_vld_top: code set needs an 11-bit window");
   end

   logic [WIN_W-1:0] win;
   logic             win_ok;
   logic [SZ_W-1:0]  d_size;
   logic [SZ_W-1:0]  d_len;
   logic             d_err;

   dcsz_bitbuf #(.WIN_W(WIN_W), .WORD_W(WORD_W), .LEN_W(SZ_W)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_data  (word_data),
      .word_valid (word_valid),
      .word_req   (word_req),
      .win        (win),
      .win_ok     (win_ok),
      .adv_len    (d_len)
   );

   dcsz_decode #(.WIN_W(WIN_W), .SHORT_W(SHORT_W)) u_dec (
      .win  (win),
      .size (d_size),
      .len  (d_len),
      .err  (d_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_valid <= 1'b0;
         sym_size  <= '0;
         sym_len   <= '0;
         sym_err   <= 1'b0;
      end else begin
         sym_valid <= win_ok;
         sym_size  <= d_size;
         sym_len   <= d_len;
         sym_err   <= win_ok & d_err;
      end
   end

endmodule

// File: rtl/dcsz_vld_chk.sv
module dcsz_vld_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       word_req,
   input logic       sym_valid,
   input logic [3:0] sym_size,
   input logic [3:0] sym_len,
   input logic       sym_err
);

   AST_SHORT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && !sym_err && sym_size <= 4'd6) |-> (sym_len >= 4'd2 && sym_len <= 4'd5)); // R1

   AST_LONG_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && !sym_err && sym_size >= 4'd4) |-> (sym_len == sym_size - 4'd1)); // R2

   AST_ERR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && sym_err) |-> (sym_len == 4'd0 && sym_size == 4'd0)); // R3

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && sym_err) |=> (sym_valid && sym_err)); // R3

   AST_REQ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      word_req |=> !sym_valid); // R6

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !word_req |=> sym_valid); // R7

   AST_ERR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      sym_err |-> sym_valid); // R3

endmodule

bind dcsz_vld_top dcsz_vld_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .word_req  (word_req),
   .sym_valid (sym_valid),
   .sym_size  (sym_size),
   .sym_len   (sym_len),
   .sym_err   (sym_err)
);

// File: tb/dcsz_vld_top_test.sv
module dcsz_vld_top_test;

   localparam int NRAND = 200;
   localparam int NSYM  = 13 + NRAND;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] word_data;
   logic        word_valid;
   logic        word_req;
   logic        sym_valid;
   logic [3:0]  sym_size;
   logic [3:0]  sym_len;
   logic        sym_err;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   bit ended  = 1'b0;

   logic        stream [0:4095];
   logic [31:0] words  [0:127];
   int          exp_sz [0:NSYM-1];
   int          nbits  = 0;
   int          nwords = 0;

   always #5 clk = ~clk;

   dcsz_vld_top uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_data  (word_data),
      .word_valid (word_valid),
      .word_req   (word_req),
      .sym_valid  (sym_valid),
      .sym_size   (sym_size),
      .sym_len    (sym_len),
      .sym_err    (sym_err)
   );

   function automatic int code_len(input int s);
      if (s == 1 || s == 2) return 2;
      if (s == 0 || s == 3) return 3;
      return s - 1;
   endfunction

   function automatic int code_val(input int s);
      case (s)
         0: return 3;
         1: return 3;
         2: return 2;
         3: return 2;
         default: return 1;
      endcase
   endfunction

   task automatic put_code(input int s);
      int l = code_len(s);
      int v = code_val(s);
      for (int i = l - 1; i >= 0; i--) begin
         stream[nbits] = v[i];
         nbits++;
      end
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      for (int s = 0; s < 13; s++) exp_sz[s] = s;
      for (int i = 13; i < NSYM; i++) exp_sz[i] = $urandom_range(12, 0);
      for (int i = 0; i < 4096; i++) stream[i] = 1'b0;
      for (int i = 0; i < NSYM; i++) put_code(exp_sz[i]);
      nwords = (nbits + 31) / 32 + 1;
      for (int w = 0; w < nwords; w++)
         for (int j = 0; j < 32; j++) words[w][31-j] = stream[32*w + j];

      rst_n = 1'b0;
      word_valid = 1'b0;
      word_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(sym_valid == 1'b0, "R8", "sym_valid in reset", int'(sym_valid), 0);
      chk(sym_err == 1'b0, "R8", "sym_err in reset", int'(sym_err), 0);
      chk(word_req == 1'b1, "R8", "word_req in reset", int'(word_req), 1);
      rst_n = 1'b1;
      begin
         int widx = 0;
         while (!done) begin
            @(negedge clk);
            word_valid = 1'b0;
            if (word_req && widx < nwords) begin
               word_valid = 1'b1;
               word_data  = words[widx];
            end
            @(posedge clk);
            if (word_valid) widx++;
         end
      end
   end

   initial begin
      int k = 0;
      int nerr = 0;
      int prev_req = 1;
      @(posedge rst_n);
      while (!done) begin
         @(negedge clk);
         if (prev_req == 1)
            chk(!sym_valid, "R6", "sym_valid after word_req", int'(sym_valid), 0);
         if (sym_valid) begin
            if (k < NSYM) begin
               string rq;
               rq = (exp_sz[k] <= 6) ? "R1" : "R2";
               chk(!sym_err && sym_size == 4'(exp_sz[k]) &&
                   sym_len == 4'(code_len(exp_sz[k])), k < 13 ? rq : "R4",
                   $sformatf("symbol %0d size*16+len err=%0d", k, sym_err),
                   int'(sym_size) * 16 + int'(sym_len),
                   exp_sz[k] * 16 + code_len(exp_sz[k]));
               k++;
            end else begin
               chk(sym_err && sym_len == 4'd0 && sym_size == 4'd0, "R3",
                   "zero window err*256+size*16+len",
                   int'(sym_err) * 256 + int'(sym_size) * 16 + int'(sym_len), 256);
               nerr++;
               if (nerr == 3) done = 1'b1;
            end
         end
         prev_req = int'(word_req);
      end
      chk(k == NSYM, "R5", "symbols decoded in order", k, NSYM);
      finish_run();
   end

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule